// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block holds the software-visible state of a four-channel DMA engine. A simple bus slave port lets the processor program each channel's control word, its current memory address and its remaining byte count. It also lets the processor read back a shared interrupt status register. Bus reads are combinational. A read's side effect and any write take effect at the next rising clock edge.

The data-moving engine reports progress to the bank, one lane per channel. A byte-count strobe advances the channel's address and reduces its remaining count. A completion pulse can raise the channel's interrupt status bit. Any set status bit pulls the active-low interrupt line to the processor. Reading the status register returns it and clears it in the same access, so one read acknowledges all pending channels.

Channel groups sit at a 0x10 stride from a base of 0x200. Control is at +0x4, address at +0x8 and count at +0xC. The status register occupies +0x0 of the first group only.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every control, address, count and status register reads 0 and `irq_n` is 1.
- R2: Each channel k (0 to 3) has a control register at 0x204+0x10·k, an address register at 0x208+0x10·k and a count register at 0x20C+0x10·k. Control keeps `bus_wdata[9:0]` and reads back zero-extended. Count keeps all 32 bits.
- R3: Bits [1:0] of every address register always read 0. A write stores only bits [31:2], so writing 0xFFFFFFFF reads back 0xFFFFFFFC.
- R4: On a progress strobe, the address becomes (address + moved bytes) with bits [1:0] forced to 0. The moved bytes are the strobe's byte count clipped to the remaining count.
- R5: On a progress strobe, the count drops by the moved bytes. It saturates at 0 and never wraps.
- R6: A bus write to a channel's address or count register in the same cycle as a progress strobe wins for that register. The written value is stored, and the progress has no effect on that register.
- R7: A completion pulse on channel k sets status bit k only when control bit 3 (interrupt enable) is 1 in that cycle and the count after that cycle's update is 0. Otherwise the pulse has no effect.
- R8: The status register at 0x200 returns channel k's bit in bit k, with bits [31:4] zero. A read clears every bit not set again in the same cycle.
- R9: A status bit set in the same cycle as a status read stays set after the read. The read itself returns the value from before that event.
- R10: `irq_n` is 0 exactly when any status bit is set.
- R11: A read of an unmapped or non-word-aligned offset returns 0. A write to such an offset changes no register.
- R12: The status register is read-only. A write to 0x200 neither sets nor clears any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| xfer_valid | input | 4 | Per-channel progress strobe |
| xfer_bytes | input | 64 | Per-channel moved-byte count, 16 bits per channel, channel k at [16k+15:16k] |
| xfer_done | input | 4 | Per-channel completion pulse |
| irq_n | output | 1 | Active-low interrupt to the processor |

## Verification
The hardest situations to reach are collisions. One is a completion event landing in the same cycle as the status read that would clear it. The other is a software write landing on a register that a progress strobe is updating. Neither arises from ordinary register traffic. Directed sequences build each collision on purpose. A channel is first driven to a zero count with interrupts enabled, and then the pulse and the read are issued together. A seeded random phase then mixes bus accesses, strobes larger than the remaining count and pulses on all channels at once. A bench model checks every read against these rules.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int DW      = 32;
  localparam int CTRLW   = 10;
  localparam int BCW     = 16;
  localparam int IEN_BIT = 3;
  localparam int STATW   = 8;

  // bytes actually moved: request clipped to what remains
  function automatic logic [DW-1:0] clip_bytes(input logic [BCW-1:0] req,
                                               input logic [DW-1:0]  remain);
    logic [DW-1:0] r;
    r = {{(DW-BCW){1'b0}}, req};
    return (r > remain) ? remain : r;
  endfunction

  function automatic logic [DW-1:0] align_word(input logic [DW-1:0] a);
    return {a[DW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode #(
  parameter int          NCH  = 4,
  parameter int          AW   = 12,
  parameter logic [11:0] BASE = 12'h200
) (
  input  logic [AW-1:0]  addr,
  output logic           stat_hit,
  output logic [NCH-1:0] ctrl_hit,
  output logic [NCH-1:0] addr_hit,
  output logic [NCH-1:0] cnt_hit
);
  localparam int SPAN = NCH * 16;
  logic [AW-1:0] rel;
  logic          in_win;

  always_comb begin
    rel      = addr - AW'(BASE);
    in_win   = (addr >= AW'(BASE)) && (int'(rel) < SPAN);
    stat_hit = 1'b0;
    ctrl_hit = '0;
    addr_hit = '0;
    cnt_hit  = '0;
    if (in_win) begin
      for (int i = 0; i < NCH; i++) begin
        if (int'(rel[AW-1:4]) == i) begin
          case (rel[3:0])
            4'h0: stat_hit    = (i == 0);
            4'h4: ctrl_hit[i] = 1'b1;
            4'h8: addr_hit[i] = 1'b1;
            4'hC: cnt_hit[i]  = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_addr,
  input  logic             wr_cnt,
  input  logic [DW-1:0]    wdata,
  input  logic             prog_valid,
  input  logic [BCW-1:0]   prog_bytes,
  input  logic             done,
  output logic [CTRLW-1:0] ctrl_q,
  output logic [DW-1:0]    addr_q,
  output logic [DW-1:0]    cnt_q,
  output logic             irq_set
);
  logic [DW-1:0] step_b, cnt_d, addr_d;

  always_comb begin
    step_b  = prog_valid ? clip_bytes(prog_bytes, cnt_q) : '0;
    cnt_d   = wr_cnt  ? wdata : (cnt_q - step_b);
    addr_d  = wr_addr ? align_word(wdata) : align_word(addr_q + step_b);
    irq_set = done && ctrl_q[IEN_BIT] && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRLW-1:0];
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: without a software write the count can only fall or hold
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> cnt_q <= $past(cnt_q));

  // R6: a software write to the count beats any progress
  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq
  import dma_rb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_rd,
  input  logic [NCH-1:0]   set_vec,
  output logic [NCH-1:0]   status_q,
  output logic [STATW-1:0] status,
  output logic             irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (stat_rd ? '0 : status_q) | set_vec;
  end

  assign status = {{(STATW-NCH){1'b0}}, status_q};
  assign irq_n  = ~|status_q;

  // R8: a read leaves only what was raised in that same cycle (R9)
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> status_q == $past(set_vec));

  // R9: without a read no set bit is ever lost
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (status_q & $past(status_q)) == $past(status_q));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int          NCH  = 4,
  parameter int          AW   = 12,
  parameter logic [11:0] BASE = 12'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCH-1:0]   xfer_valid,
  input  logic [NCH*BCW-1:0] xfer_bytes,
  input  logic [NCH-1:0]   xfer_done,
  output logic             irq_n
);
  logic                       stat_hit;
  logic [NCH-1:0]             ctrl_hit, addr_hit, cnt_hit;
  logic                       wr_en, rd_en, stat_rd;
  logic [NCH-1:0][CTRLW-1:0]  ctrl_q;
  logic [NCH-1:0][DW-1:0]     addr_q, cnt_q;
  logic [NCH-1:0]             set_vec, stat_vec;
  logic [STATW-1:0]           status;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign stat_rd = rd_en && stat_hit;

  dma_rb_decode #(.NCH(NCH), .AW(AW), .BASE(BASE)) dec_i (
    .addr(bus_addr), .stat_hit(stat_hit),
    .ctrl_hit(ctrl_hit), .addr_hit(addr_hit), .cnt_hit(cnt_hit)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dma_rb_chan ch_i (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr_en && ctrl_hit[k]),
      .wr_addr(wr_en && addr_hit[k]),
      .wr_cnt(wr_en && cnt_hit[k]),
      .wdata(bus_wdata),
      .prog_valid(xfer_valid[k]),
      .prog_bytes(xfer_bytes[k*BCW +: BCW]),
      .done(xfer_done[k]),
      .ctrl_q(ctrl_q[k]), .addr_q(addr_q[k]), .cnt_q(cnt_q[k]),
      .irq_set(set_vec[k])
    );

    // R7: a status bit rises only if that channel had interrupts enabled
    p_set_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_vec[k]) |-> $past(ctrl_q[k][IEN_BIT]));
  end

  dma_rb_irq #(.NCH(NCH)) irq_i (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .set_vec(set_vec),
    .status_q(stat_vec), .status(status), .irq_n(irq_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (stat_hit) bus_rdata = {{(DW-STATW){1'b0}}, status};
      for (int i = 0; i < NCH; i++) begin
        if (ctrl_hit[i]) bus_rdata = {{(DW-CTRLW){1'b0}}, ctrl_q[i]};
        if (addr_hit[i]) bus_rdata = addr_q[i];
        if (cnt_hit[i])  bus_rdata = cnt_q[i];
      end
    end
  end

  // R3: an address register never shows its two low bits
  p_addr_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && |addr_hit) |-> bus_rdata[1:0] == 2'b00);
endmodule

// File: tb/dma_regbank_tb_top.sv
module dma_regbank_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel, wr;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [NCH-1:0] xv, xd;
  logic [NCH*16-1:0] xb;
  logic        irq_n;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [9:0]  m_ctrl [NCH];
  logic [31:0] m_addr [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [3:0]  m_stat;
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  dma_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .xfer_valid(xv), .xfer_bytes(xb),
    .xfer_done(xd), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // class: 0 unmapped, 1 status, 2 ctrl, 3 address, 4 count
  function automatic int cls(input logic [11:0] a, output int ch);
    int rel;
    ch = 0;
    if (a < 12'h200 || a >= 12'h240) return 0;
    rel = int'(a) - 'h200;
    ch = rel / 16;
    case (rel % 16)
      0:  return (ch == 0) ? 1 : 0;
      4:  return 2;
      8:  return 3;
      12: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int ch;
    case (cls(a, ch))
      1: return {28'd0, m_stat};
      2: return {22'd0, m_ctrl[ch]};
      3: return m_addr[ch];
      4: return m_cnt[ch];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    int ch;
    case (cls(a, ch))
      1: return "R8";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic idle();
    sel = 0; wr = 0; addr = '0; wdata = '0; xv = '0; xd = '0; xb = '0;
  endtask

  // inputs are driven just after a falling edge; sample then update model
  task automatic cycle();
    logic [31:0] e, step, nc, na;
    logic [3:0]  setv;
    int c, ch;
    #5;
    if (sel && !wr) begin
      e = exp_read(addr);
      chk(rdata === e, tag_of(addr), rdata, e);
      last_rd = rdata;
    end
    chk(irq_n === (m_stat == 0), "R10", {31'd0, irq_n}, {31'd0, m_stat == 0});
    c = cls(addr, ch);
    setv = '0;
    for (int k = 0; k < NCH; k++) begin
      step = 32'(xb[k*16 +: 16]);
      if (step > m_cnt[k]) step = m_cnt[k];
      if (!xv[k]) step = 0;
      nc = (sel && wr && c == 4 && ch == k) ? wdata : m_cnt[k] - step;
      na = (sel && wr && c == 3 && ch == k) ? wdata : m_addr[k] + step;
      na[1:0] = 2'b00;
      if (xd[k] && m_ctrl[k][3] && nc == 0) setv[k] = 1'b1;
      if (sel && wr && c == 2 && ch == k) m_ctrl[k] = wdata[9:0];
      m_cnt[k] = nc;
      m_addr[k] = na;
    end
    m_stat = ((sel && !wr && c == 1) ? 4'd0 : m_stat) | setv;
    @(negedge clk);
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    idle(); sel = 1; wr = 1; addr = a; wdata = d; cycle();
  endtask

  task automatic brd(input logic [11:0] a);
    idle(); sel = 1; addr = a; cycle();
  endtask

  function automatic logic [11:0] pick_addr();
    int r;
    r = $urandom % 16;
    if (r == 0) return 12'h200;
    if (r < 13) return 12'(12'h200 + ((r - 1) / 3) * 16 + 4 * ((r - 1) % 3 + 1));
    return 12'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NCH; k++) begin
      m_ctrl[k] = '0; m_addr[k] = '0; m_cnt[k] = '0;
    end
    m_stat = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every register reads zero after reset
    for (int i = 0; i < 13; i++) begin
      brd(i == 0 ? 12'h200 : 12'(12'h200 + ((i - 1) / 3) * 16 + 4 * ((i - 1) % 3 + 1)));
      chk(last_rd == 0, "R1", last_rd, 0);
    end
    chk(irq_n == 1'b1, "R1", {31'd0, irq_n}, 1);

    // R2: control keeps ten bits
    bwr(12'h214, 32'hFFFF_FFFF); brd(12'h214);
    chk(last_rd == 32'h3FF, "R2", last_rd, 32'h3FF);
    // R3: low address bits dropped
    bwr(12'h228, 32'hFFFF_FFFF); brd(12'h228);
    chk(last_rd == 32'hFFFF_FFFC, "R3", last_rd, 32'hFFFF_FFFC);

    // R4/R5: clip progress to remaining count
    bwr(12'h208, 32'h100); bwr(12'h20C, 32'd10); bwr(12'h204, 32'h8);
    idle(); xv[0] = 1; xb[15:0] = 16'd100; cycle();
    brd(12'h20C); chk(last_rd == 0, "R5", last_rd, 0);
    brd(12'h208); chk(last_rd == 32'h108, "R4", last_rd, 32'h108);

    // R6: write collides with progress
    bwr(12'h21C, 32'd50);
    idle(); sel = 1; wr = 1; addr = 12'h21C; wdata = 32'd77; xv[1] = 1; xb[31:16] = 16'd5; cycle();
    brd(12'h21C); chk(last_rd == 32'd77, "R6", last_rd, 32'd77);

    // R7: pulse with enable off (ch2 count 0) has no effect
    idle(); xd[2] = 1; cycle();
    brd(12'h200); chk(last_rd == 0, "R7", last_rd, 0);
    // R7: enabled ch0 at zero count raises bit 0
    idle(); xd[0] = 1; cycle();
    chk(irq_n == 1'b0, "R10", {31'd0, irq_n}, 0);
    // R12: status write ignored
    bwr(12'h200, 32'h0);
    brd(12'h200); chk(last_rd == 32'h1, "R12", last_rd, 1);
    brd(12'h200); chk(last_rd == 32'h0, "R8", last_rd, 0);

    // R9: pulse during status read survives the read
    bwr(12'h214, 32'h8); bwr(12'h21C, 32'h0);
    idle(); sel = 1; addr = 12'h200; xd[1] = 1; cycle();
    chk(last_rd == 0, "R9", last_rd, 0);
    brd(12'h200); chk(last_rd == 32'h2, "R9", last_rd, 2);

    // R11: unmapped and unaligned offsets
    bwr(12'h210, 32'hDEAD_BEEF); bwr(12'h205, 32'h0); bwr(12'h1FC, 32'h1234);
    brd(12'h210); chk(last_rd == 0, "R11", last_rd, 0);
    brd(12'h209); chk(last_rd == 0, "R11", last_rd, 0);
    brd(12'h204); chk(last_rd == 32'h8, "R11", last_rd, 32'h8);

    // seeded random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      idle();
      op = $urandom % 10;
      if (op < 7) begin
        sel = 1; addr = pick_addr(); wr = (op >= 4);
        wdata = (addr[3:0] == 4'hC) ? ($urandom % 2048) : $urandom;
      end
      for (int k = 0; k < NCH; k++) begin
        xv[k] = ($urandom % 3) == 0;
        xb[k*16 +: 16] = 16'($urandom % 512);
        xd[k] = ($urandom % 4) == 0;
      end
      cycle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule